// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers the interrupt sources of a network controller into eight status bits. An eight-bit enable mask, which the host reads and writes, selects which of those bits drive a single active-high interrupt line. The status bits do not all clear the same way. Some sources are one-cycle events that latch a sticky bit, which stays set until the host writes a 1 to it through the acknowledge path. Other sources are levels, and their status bit simply follows the input one cycle later.

One source is generated inside the block: an early-receive detector. While a frame is arriving, it counts the bytes stored and compares the count with a threshold the host can program. This lets software start on a frame before the whole frame has landed.

The host reaches the block through a small register bus with two byte lanes. Word address 0 carries the status and acknowledge byte in the low lane and the mask in the high lane. Word address 1 holds the 16-bit early-receive threshold. Reads are combinational and writes take effect at the clock edge. The interrupt line is registered.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the mask is 0x00, all status bits are 0, the threshold is 0x0000 and `irq` is low.
- R2: Each write lane is gated by its byte enable. At address 0, `bus_be[1]` writes the mask from `bus_wdata[15:8]`. At address 1, `bus_be[0]` writes threshold bits 7:0 and `bus_be[1]` writes bits 15:8. A lane whose enable is low changes nothing.
- R3: `irq` equals the OR over all bits of (status AND mask), registered, so it follows a status or mask change by one clock. A status bit whose mask bit is 0 never raises `irq`.
- R4: The sticky bits (status bits 1, 3, 4, 6 and 7) set on a one-cycle event. They stay set until a write to address 0 with `bus_be[0]` high puts a 1 in their bit position of `bus_wdata[7:0]`.
- R5: The level bits (status bits 0, 2 and 5) equal their `src_in` bit one clock later. Acknowledge writes have no effect on them.
- R6: When an event and an acknowledge reach the same sticky bit in the same cycle, the bit ends up set.
- R7: While `rx_active` is high, status bit 6 sets once the stored-byte count is strictly greater than the threshold. A count equal to the threshold does not set it. `src_in[6]` is ignored.
- R8: The byte count advances only on `rx_byte` while `rx_active` is high. It returns to zero whenever `rx_active` is low, so every frame starts counting from zero.
- R9: Once set, status bit 6 stays set after `rx_active` falls, until it is acknowledged.
- R10: A read of address 0 returns {mask, status}. A read of address 1 returns the threshold. Reads of addresses 2 and 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_in | input | 8 | Source inputs: a one-cycle pulse for sticky bits, a level for level bits, bit 6 unused |
| rx_active | input | 1 | High while a frame is being received |
| rx_byte | input | 1 | One byte of the current frame stored this cycle |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Word address |
| bus_be | input | 2 | Byte enables, bit 0 for the low lane |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| irq | output | 1 | Registered active-high interrupt line |

## Verification
The hardest case to reach from the ports is an event and an acknowledge landing on one sticky bit in the very same cycle. Each bench task drives the event pulse and the acknowledge write on the same falling clock edge, so both are seen at one rising edge. The threshold boundary is also hard to hit exactly. The bench counts bytes until the count equals the threshold and checks that the early-receive bit is still clear. It then adds one more byte and checks that the bit sets. To show that the count restarts, it feeds bytes while no frame is active, then opens a short frame that stays below the threshold.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC   = 8;
  localparam int DATA_W    = 16;
  localparam int CNT_W     = 16;
  localparam int ADDR_W    = 2;

  localparam int BIT_RX    = 0;
  localparam int BIT_TX    = 1;
  localparam int BIT_TXE   = 2;
  localparam int BIT_ALLOC = 3;
  localparam int BIT_OVRN  = 4;
  localparam int BIT_EXC   = 5;
  localparam int BIT_ERX   = 6;
  localparam int BIT_PHY   = 7;

  // 1 = status bit follows a level, 0 = sticky until acknowledged
  localparam logic [NUM_SRC-1:0] LEVEL_KIND = 8'b0010_0101;

  localparam logic [ADDR_W-1:0] ADR_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_THR  = 2'd1;
endpackage

// File: rtl/irq_bus_regs.sv
module irq_bus_regs
  import irq_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int TW = CNT_W,
  parameter int DW = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_be,
  input  logic [DW-1:0]     bus_wdata,
  input  logic [N-1:0]      status,
  output logic [N-1:0]      mask,
  output logic [TW-1:0]     thresh,
  output logic [N-1:0]      ack,
  output logic [DW-1:0]     bus_rdata
);
  localparam int LANE = DW / 2;

  logic          wr;
  logic          mask_en;
  logic [1:0]    thr_en;
  logic [N-1:0]  mask_nxt;
  logic [TW-1:0] thr_nxt;

  assign wr = bus_sel & bus_we;

  always_comb begin
    mask_en  = wr && (bus_addr == ADR_STAT) && bus_be[1];
    thr_en   = (wr && (bus_addr == ADR_THR)) ? bus_be : 2'b00;
    mask_nxt = bus_wdata[DW-1 -: N];
    thr_nxt  = thresh;
    if (thr_en[0]) thr_nxt[LANE-1:0]  = bus_wdata[LANE-1:0];
    if (thr_en[1]) thr_nxt[TW-1:LANE] = bus_wdata[DW-1:LANE];
    ack = (wr && (bus_addr == ADR_STAT) && bus_be[0]) ? bus_wdata[N-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask   <= '0;
      thresh <= '0;
    end else begin
      if (mask_en)    mask   <= mask_nxt;
      if (|thr_en)    thresh <= thr_nxt;
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_STAT: bus_rdata = {mask, status};
      ADR_THR:  bus_rdata = thresh;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_early_rx.sv
module irq_early_rx
  import irq_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_active,
  input  logic          rx_byte,
  input  logic [CW-1:0] thresh,
  output logic          hit
);
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          cnt_en;

  always_comb begin
    cnt_en  = 1'b0;
    cnt_nxt = cnt_q;
    if (!rx_active) begin
      cnt_en  = (cnt_q != '0);
      cnt_nxt = '0;
    end else if (rx_byte && (cnt_q != {CW{1'b1}})) begin
      cnt_en  = 1'b1;
      cnt_nxt = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign hit = rx_active && (cnt_q > thresh);
endmodule

// File: rtl/irq_status_bits.sv
module irq_status_bits
  import irq_pkg::*;
#(
  parameter int               N    = NUM_SRC,
  parameter logic [N-1:0]     KIND = LEVEL_KIND
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] ack,
  output logic [N-1:0] status
);
  logic [N-1:0] st_nxt;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (KIND[i]) begin : g_level
      always_comb st_nxt[i] = lvl[i];
    end else begin : g_sticky
      always_comb st_nxt[i] = evt[i] | (status[i] & ~ack[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= st_nxt;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic              rx_active,
  input  logic              rx_byte,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [1:0]         rst_sync;
  logic               rst_ns;
  logic [NUM_SRC-1:0] status_q, mask_q, ack_v, evt_v;
  logic [CNT_W-1:0]   thresh_q;
  logic               erx_hit;
  logic               irq_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  irq_bus_regs #(.N(NUM_SRC), .TW(CNT_W), .DW(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_ns), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .status(status_q), .mask(mask_q), .thresh(thresh_q), .ack(ack_v),
    .bus_rdata(bus_rdata)
  );

  irq_early_rx #(.CW(CNT_W)) u_erx (
    .clk(clk), .rst_n(rst_ns), .rx_active(rx_active), .rx_byte(rx_byte),
    .thresh(thresh_q), .hit(erx_hit)
  );

  always_comb begin
    evt_v         = src_in;
    evt_v[BIT_ERX] = erx_hit;
  end

  irq_status_bits #(.N(NUM_SRC), .KIND(LEVEL_KIND)) u_bits (
    .clk(clk), .rst_n(rst_ns), .evt(evt_v), .lvl(src_in), .ack(ack_v),
    .status(status_q)
  );

  assign irq_nxt = |(status_q & mask_q);

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) irq <= 1'b0;
    else         irq <= irq_nxt;
  end
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] mask,
  input logic [NUM_SRC-1:0] src_in,
  input logic               rx_active,
  input logic               bus_sel,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [1:0]         bus_be,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               irq
);
  logic [NUM_SRC-1:0] ack_seen;
  assign ack_seen = (bus_sel && bus_we && bus_addr == ADR_STAT && bus_be[0])
                    ? bus_wdata[NUM_SRC-1:0] : '0;

  assert_irq_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|(status & mask)));

  assert_phy_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status[BIT_PHY] && !ack_seen[BIT_PHY] |=> status[BIT_PHY]);

  assert_exc_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> status[BIT_EXC] == $past(src_in[BIT_EXC]));

  assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    src_in[BIT_TX] |=> status[BIT_TX]);

  assert_erx_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[BIT_ERX]) |-> $past(rx_active));
endmodule

bind irq_status_ctrl irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_ns), .status(status_q), .mask(mask_q),
  .src_in(src_in), .rx_active(rx_active), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .irq(irq)
);

// File: tb/sim_irq_status_ctrl.sv
`timescale 1ns/1ps
module sim_irq_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  src_in;
  logic        rx_active, rx_byte;
  logic        bus_sel, bus_we;
  logic [1:0]  bus_addr, bus_be;
  logic [15:0] bus_wdata, bus_rdata;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  irq_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .rx_active(rx_active),
    .rx_byte(rx_byte), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [1:0] be, logic [15:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    cyc();
    bus_sel = 0; bus_we = 0; bus_be = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a; bus_be = 2'b11;
    #0.5 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic pulse(int b);
    src_in[b] = 1'b1; cyc(); src_in[b] = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd0, d); check("R1 mask/status", d, 16'h0000);
    rd(2'd1, d); check("R1 threshold", d, 16'h0000);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_bytes();
    logic [15:0] d;
    wr(2'd0, 2'b10, 16'hA5FF);
    rd(2'd0, d); check("R2 mask high lane only", d, 16'hA500);
    wr(2'd0, 2'b01, 16'h3C00);
    rd(2'd0, d); check("R2 mask untouched by low lane", d, 16'hA500);
    wr(2'd1, 2'b01, 16'h1234);
    rd(2'd1, d); check("R2 threshold low lane", d, 16'h0034);
    wr(2'd1, 2'b10, 16'hAB00);
    rd(2'd1, d); check("R10 threshold read", d, 16'hAB34);
    rd(2'd2, d); check("R10 addr 2 zero", d, 16'h0000);
    rd(2'd3, d); check("R10 addr 3 zero", d, 16'h0000);
    wr(2'd0, 2'b10, 16'h0000);
  endtask

  task automatic t_sticky();
    logic [15:0] d;
    wr(2'd0, 2'b10, 16'h0200);
    pulse(1);
    check("R3 irq lags status", irq, 0);
    rd(2'd0, d); check("R4 tx bit set", d, 16'h0202);
    cyc();
    check("R3 irq raised", irq, 1);
    cyc(4);
    rd(2'd0, d); check("R4 tx bit held", d, 16'h0202);
    wr(2'd0, 2'b01, 16'h0002);
    rd(2'd0, d); check("R4 tx bit acked", d, 16'h0200);
    cyc();
    check("R3 irq dropped", irq, 0);
    pulse(7); cyc(2);
    check("R3 masked phy bit no irq", irq, 0);
    rd(2'd0, d); check("R4 phy bit set", d, 16'h0280);
    wr(2'd0, 2'b01, 16'h0080);
    wr(2'd0, 2'b10, 16'h0000);
  endtask

  task automatic t_level();
    logic [15:0] d;
    src_in[5] = 1'b1; cyc();
    rd(2'd0, d); check("R5 level bit follows", d, 16'h0020);
    wr(2'd0, 2'b01, 16'h0020);
    rd(2'd0, d); check("R5 ack ignored", d, 16'h0020);
    src_in[5] = 1'b0; cyc();
    rd(2'd0, d); check("R5 level bit cleared", d, 16'h0000);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    pulse(3);
    src_in[3] = 1'b1;
    wr(2'd0, 2'b01, 16'h0008);
    src_in[3] = 1'b0;
    rd(2'd0, d); check("R6 event wins over ack", d, 16'h0008);
    wr(2'd0, 2'b01, 16'h0008);
    rd(2'd0, d); check("R6 later ack clears", d, 16'h0000);
  endtask

  task automatic t_early();
    logic [15:0] d;
    wr(2'd1, 2'b11, 16'h0003);
    wr(2'd0, 2'b10, 16'h4000);
    src_in[6] = 1'b1; cyc(2); src_in[6] = 1'b0;
    rd(2'd0, d); check("R7 src bit 6 ignored", d, 16'h4000);
    rx_active = 1; cyc();
    rx_byte = 1; cyc(3); rx_byte = 0; cyc(2);
    rd(2'd0, d); check("R7 equal count no set", d, 16'h4000);
    rx_byte = 1; cyc(); rx_byte = 0; cyc();
    rd(2'd0, d); check("R7 count above threshold sets", d, 16'h4040);
    cyc();
    check("R3 irq from early receive", irq, 1);
    rx_active = 0; cyc(3);
    rd(2'd0, d); check("R9 held after frame end", d, 16'h4040);
    wr(2'd0, 2'b01, 16'h0040);
    rd(2'd0, d); check("R9 acked", d, 16'h4000);
    rx_byte = 1; cyc(10); rx_byte = 0;
    rx_active = 1; cyc();
    rx_byte = 1; cyc(2); rx_byte = 0; cyc(3);
    rd(2'd0, d); check("R8 count restarts per frame", d, 16'h4000);
    rx_active = 0; cyc();
    wr(2'd0, 2'b10, 16'h0000);
  endtask

  initial begin
    rst_n = 0; src_in = 0; rx_active = 0; rx_byte = 0;
    bus_sel = 0; bus_we = 0; bus_addr = 0; bus_be = 0; bus_wdata = 0;
    cyc(3); rst_n = 1; cyc(4);
    t_reset();
    t_bytes();
    t_sticky();
    t_level();
    t_collide();
    t_early();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule